// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps track of load-linked reservations for one memory and decides, for every store that reaches the memory, whether the write may go ahead. It sits next to the memory port and watches two request channels. The load channel carries reads. A read marked as linked records a reservation for the 16-byte granule it touches, tagged with the requesting hardware context. The store channel carries plain stores and store-conditionals.

For every store the block returns a registered response one cycle later. The response says whether the write is permitted and, for a store-conditional, whether it succeeded. A plain store is always permitted. A store-conditional is permitted only when the same context still holds a reservation on that granule.

Any store that writes removes every reservation on its granule, whichever context owns it. The reservations live in a small fixed table. Each context holds at most one entry. When the table is full, the oldest entry makes room for a new one.

Top module: `llsc_reservation_monitor`

## Requirements
- R1: Addresses are compared at 16-byte granule level: the low 4 address bits are ignored, so two addresses that differ only in bits [3:0] hit the same reservation.
- R2: A linked load (`ld_valid`=1, `ld_linked`=1) records a reservation for its granule and context. A later store-conditional from the same context to that granule returns `resp_permit`=1 and `resp_result`=1.
- R3: A store-conditional fails (`resp_permit`=0, `resp_result`=0) when no reservation on its granule belongs to its context, even if another context holds one there.
- R4: A store-conditional fails with result 0 when the table is empty.
- R5: A plain store (`st_cond`=0) always gets `resp_permit`=1 and `resp_result`=0. It removes every reservation on its granule, so a later store-conditional to that granule fails.
- R6: A successful store-conditional removes all reservations on its granule, including those held by other contexts.
- R7: A failed store-conditional leaves the table unchanged.
- R8: A context holds at most one reservation. A new linked load from that context replaces its older entry, so a store-conditional to the old granule fails.
- R9: When all ENTRIES slots are in use and a linked load from a context that holds no entry arrives, the oldest entry is evicted.
- R10: When a store and a linked load are presented in the same cycle, the store is applied first. A linked load to the stored granule therefore keeps its new reservation.
- R11: `resp_valid` is high exactly one cycle after each cycle with `st_valid`=1, and `resp_permit`/`resp_result` belong to that store. A synchronous reset drives all outputs low and empties the table.
- R12: A load with `ld_linked`=0 records no reservation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | A store request is present this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_ctx | input | CTX_W | Hardware context of the store |
| st_cond | input | 1 | 1: store-conditional, 0: plain store |
| ld_valid | input | 1 | A load request is present this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_ctx | input | CTX_W | Hardware context of the load |
| ld_linked | input | 1 | 1: linked load that takes a reservation |
| resp_valid | output | 1 | Response for the store of the previous cycle |
| resp_permit | output | 1 | 1: the store may write the memory |
| resp_result | output | 1 | Store-conditional outcome: 1 success, 0 failure |

## Verification
The assertions assume that the inputs are held low while reset is asserted. They also assume that at most one store and one load arrive per cycle, which the two-channel port list already enforces. The bench changes inputs only on the falling clock edge, and it keeps every request to a single cycle, so each request is seen by exactly one rising edge. The table-contents assertion for a failed store-conditional also assumes that no linked load arrives in the same cycle, so the bench issues that case with the load channel idle. The sweep over context pairs and address offsets always clears the granule with a plain store before the next pair. This keeps the table empty between iterations, so the expected outcome depends only on the pair under test.

// File: rtl/llsc_mon_pkg.sv
package llsc_mon_pkg;

  // Outcome of the store presented in a cycle.
  typedef enum logic [1:0] {
    ST_NONE      = 2'd0,
    ST_PLAIN     = 2'd1,
    ST_COND_OK   = 2'd2,
    ST_COND_FAIL = 2'd3
  } st_outcome_e;

  // A store that writes memory clears matching reservations.
  function automatic logic outcome_writes(st_outcome_e o);
    return (o == ST_PLAIN) || (o == ST_COND_OK);
  endfunction

endpackage

// File: rtl/llsc_match_array.sv
module llsc_match_array #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int CTX_W   = 4
) (
  input  logic [ENTRIES-1:0]             entry_valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] entry_gran,
  input  logic [ENTRIES-1:0][CTX_W-1:0]  entry_ctx,
  input  logic [ADDR_W-1:0]              probe_gran,
  input  logic [CTX_W-1:0]               probe_ctx,
  output logic [ENTRIES-1:0]             gran_hit,
  output logic [ENTRIES-1:0]             ctx_hit,
  output logic [ENTRIES-1:0]             own_hit
);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign gran_hit[i] = entry_valid[i] && (entry_gran[i] == probe_gran);
    assign ctx_hit[i]  = entry_valid[i] && (entry_ctx[i] == probe_ctx);
    assign own_hit[i]  = gran_hit[i] && ctx_hit[i];
  end

endmodule

// File: rtl/llsc_age_tracker.sv
module llsc_age_tracker #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] ins_onehot,
  input  logic [ENTRIES-1:0] live,
  output logic [ENTRIES-1:0] oldest
);

  // older_q[i][j] = 1 : entry i was written before entry j.
  logic [ENTRIES-1:0][ENTRIES-1:0] older_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_row
    localparam logic [ENTRIES-1:0] SELF = ENTRIES'(1) << i;

    always_ff @(posedge clk) begin
      if (rst) begin
        older_q[i] <= '0;
      end else begin
        for (int j = 0; j < ENTRIES; j++) begin
          if (ins_onehot[i])
            older_q[i][j] <= 1'b0;
          else if (ins_onehot[j])
            older_q[i][j] <= 1'b1;
        end
      end
    end

    // Oldest: live and older than every other live entry.
    assign oldest[i] = live[i] && (&(older_q[i] | ~live | SELF));
  end

endmodule

// File: rtl/llsc_slot_pick.sv
module llsc_slot_pick #(
  parameter int ENTRIES = 8
) (
  input  logic [ENTRIES-1:0] own_entry,
  input  logic [ENTRIES-1:0] live,
  input  logic [ENTRIES-1:0] oldest,
  output logic [ENTRIES-1:0] slot
);

  function automatic logic [ENTRIES-1:0] lowest_one(logic [ENTRIES-1:0] v);
    return v & (~v + ENTRIES'(1));
  endfunction

  always_comb begin
    if (|own_entry)
      slot = lowest_one(own_entry);
    else if (!(&live))
      slot = lowest_one(~live);
    else
      slot = lowest_one(oldest);
  end

endmodule

// File: rtl/llsc_reservation_monitor.sv
module llsc_reservation_monitor
  import llsc_mon_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int ADDR_W    = 32,
  parameter int CTX_W     = 4,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [CTX_W-1:0]  st_ctx,
  input  logic              st_cond,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CTX_W-1:0]  ld_ctx,
  input  logic              ld_linked,
  output logic              resp_valid,
  output logic              resp_permit,
  output logic              resp_result
);

  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] granule_of(logic [ADDR_W-1:0] a);
    return a & ~LOW_MASK;
  endfunction

  // Reservation table
  logic [ENTRIES-1:0]             tbl_valid;
  logic [ENTRIES-1:0][ADDR_W-1:0] tbl_gran;
  logic [ENTRIES-1:0][CTX_W-1:0]  tbl_ctx;

  // Named internal events
  logic [ENTRIES-1:0] st_gran_hit, st_ctx_hit, st_own_hit;
  logic [ENTRIES-1:0] ld_gran_hit, ld_ctx_hit, ld_own_hit;
  logic [ENTRIES-1:0] clear_vec, live_after, own_ld, oldest, slot, ld_ins;
  logic               tbl_empty, ld_fire, sc_ok;
  logic [ADDR_W-1:0]  st_gran, ld_gran;
  st_outcome_e        st_outcome;

  assign st_gran   = granule_of(st_addr);
  assign ld_gran   = granule_of(ld_addr);
  assign tbl_empty = ~|tbl_valid;
  assign ld_fire   = ld_valid && ld_linked;

  llsc_match_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_st_match (
    .entry_valid (tbl_valid),
    .entry_gran  (tbl_gran),
    .entry_ctx   (tbl_ctx),
    .probe_gran  (st_gran),
    .probe_ctx   (st_ctx),
    .gran_hit    (st_gran_hit),
    .ctx_hit     (st_ctx_hit),
    .own_hit     (st_own_hit)
  );

  // Load probe sees the table after the store's clears.
  llsc_match_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_ld_match (
    .entry_valid (live_after),
    .entry_gran  (tbl_gran),
    .entry_ctx   (tbl_ctx),
    .probe_gran  (ld_gran),
    .probe_ctx   (ld_ctx),
    .gran_hit    (ld_gran_hit),
    .ctx_hit     (ld_ctx_hit),
    .own_hit     (ld_own_hit)
  );

  // Store decision against the table as it stood before this cycle.
  assign sc_ok = |st_own_hit;

  always_comb begin
    if (!st_valid)
      st_outcome = ST_NONE;
    else if (!st_cond)
      st_outcome = ST_PLAIN;
    else if (sc_ok)
      st_outcome = ST_COND_OK;
    else
      st_outcome = ST_COND_FAIL;
  end

  assign clear_vec  = outcome_writes(st_outcome) ? st_gran_hit : '0;
  assign live_after = tbl_valid & ~clear_vec;
  assign own_ld     = ld_ctx_hit;

  llsc_age_tracker #(.ENTRIES(ENTRIES)) u_age (
    .clk        (clk),
    .rst        (rst),
    .ins_onehot (ld_ins),
    .live       (live_after),
    .oldest     (oldest)
  );

  llsc_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
    .own_entry (own_ld),
    .live      (live_after),
    .oldest    (oldest),
    .slot      (slot)
  );

  assign ld_ins = ld_fire ? slot : '0;

  // Table update
  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_valid <= '0;
      tbl_gran  <= '0;
      tbl_ctx   <= '0;
    end else begin
      tbl_valid <= live_after | ld_ins;
      for (int i = 0; i < ENTRIES; i++) begin
        if (ld_ins[i]) begin
          tbl_gran[i] <= ld_gran;
          tbl_ctx[i]  <= ld_ctx;
        end
      end
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_permit <= 1'b0;
      resp_result <= 1'b0;
    end else begin
      resp_valid  <= (st_outcome != ST_NONE);
      resp_permit <= outcome_writes(st_outcome);
      resp_result <= (st_outcome == ST_COND_OK);
    end
  end

endmodule

// File: rtl/llsc_monitor_checker.sv
module llsc_monitor_checker
  import llsc_mon_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               st_valid,
  input logic               st_cond,
  input logic               ld_fire,
  input logic               tbl_empty,
  input logic [ENTRIES-1:0] tbl_valid,
  input logic [ENTRIES-1:0] ld_ins,
  input st_outcome_e        st_outcome,
  input logic               resp_valid,
  input logic               resp_permit,
  input logic               resp_result
);

  assert_result_needs_permit_R2: assert property (@(posedge clk) disable iff (rst)
    resp_result |-> resp_permit);

  assert_ll_records_R2: assert property (@(posedge clk) disable iff (rst)
    ld_fire |=> !tbl_empty);

  assert_empty_sc_fails_R4: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_cond && tbl_empty) |=> (!resp_permit && !resp_result));

  assert_plain_permitted_R5: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_cond) |=> (resp_permit && !resp_result));

  assert_failed_sc_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (st_outcome == ST_COND_FAIL && !ld_fire) |=> (tbl_valid == $past(tbl_valid)));

  assert_one_slot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ld_ins));

  assert_resp_timing_R11: assert property (@(posedge clk) disable iff (rst)
    st_valid |=> resp_valid);

  assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (rst)
    !st_valid |=> (!resp_valid && !resp_permit && !resp_result));

endmodule

bind llsc_reservation_monitor llsc_monitor_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st_valid    (st_valid),
  .st_cond     (st_cond),
  .ld_fire     (ld_fire),
  .tbl_empty   (tbl_empty),
  .tbl_valid   (tbl_valid),
  .ld_ins      (ld_ins),
  .st_outcome  (st_outcome),
  .resp_valid  (resp_valid),
  .resp_permit (resp_permit),
  .resp_result (resp_result)
);

// File: tb/llsc_reservation_monitor_test.sv
`timescale 1ns/1ps
module llsc_reservation_monitor_test;

  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 16;
  localparam int CTX_W   = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              st_valid = 1'b0, st_cond = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0, ld_addr = '0;
  logic [CTX_W-1:0]  st_ctx = '0, ld_ctx = '0;
  logic              ld_valid = 1'b0, ld_linked = 1'b0;
  logic              resp_valid, resp_permit, resp_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  llsc_reservation_monitor #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CTX_W(CTX_W), .GRAN_BITS(4)) uut (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_addr(st_addr), .st_ctx(st_ctx), .st_cond(st_cond),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ctx(ld_ctx), .ld_linked(ld_linked),
    .resp_valid(resp_valid), .resp_permit(resp_permit), .resp_result(resp_result)
  );

  task automatic check3(string tag, logic v, logic p, logic r, logic ev, logic ep, logic er);
    checks++;
    if ({v, p, r} !== {ev, ep, er}) begin
      errors++;
      $display("FAIL %s valid/permit/result actual %b%b%b expected %b%b%b", tag, v, p, r, ev, ep, er);
    end
  endtask

  // Present store and/or load for one cycle, then check the response.
  task automatic cycle_req(string tag, bit sv, logic [ADDR_W-1:0] sa, logic [CTX_W-1:0] sc, bit cond,
                           bit lv, logic [ADDR_W-1:0] la, logic [CTX_W-1:0] lc, bit lnk,
                           bit ep, bit er);
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_ctx = sc; st_cond = cond;
    ld_valid = lv; ld_addr = la; ld_ctx = lc; ld_linked = lnk;
    @(negedge clk);
    st_valid = 1'b0; ld_valid = 1'b0; ld_linked = 1'b0; st_cond = 1'b0;
    if (sv) check3(tag, resp_valid, resp_permit, resp_result, 1'b1, ep, er);
    else    check3(tag, resp_valid, resp_permit, resp_result, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ll(logic [ADDR_W-1:0] a, logic [CTX_W-1:0] c);
    cycle_req("R2 ll", 0, '0, '0, 0, 1, a, c, 1, 0, 0);
  endtask

  task automatic sc(string tag, logic [ADDR_W-1:0] a, logic [CTX_W-1:0] c, bit ok);
    cycle_req(tag, 1, a, c, 1, 0, '0, '0, 0, ok, ok);
  endtask

  task automatic plain(string tag, logic [ADDR_W-1:0] a, logic [CTX_W-1:0] c);
    cycle_req(tag, 1, a, c, 0, 0, '0, '0, 0, 1, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] gaddr(int g, int off);
    return ADDR_W'(16'h0400 + g * 16 + off);
  endfunction

  initial begin
    int offa[3];
    int offb[5];
    offa = '{0, 5, 15};
    offb = '{0, 9, 15, 16, 31};

    repeat (3) @(negedge clk);
    // R11: reset state
    check3("R11 reset outputs", resp_valid, resp_permit, resp_result, 0, 0, 0);
    rst = 1'b0;

    // R4: empty table
    sc("R4 empty sc", gaddr(0, 0), 3'd0, 0);

    // R1 R2 R3: sweep context pairs and offsets
    for (int ca = 0; ca < 8; ca++) begin
      for (int cb = 0; cb < 8; cb++) begin
        for (int ia = 0; ia < 3; ia++) begin
          for (int ib = 0; ib < 5; ib++) begin
            logic [ADDR_W-1:0] aa, ab;
            bit same;
            aa = gaddr(1, offa[ia]);
            ab = gaddr(1, offb[ib]);
            same = ((aa >> 4) == (ab >> 4)) && (ca == cb);
            ll(aa, CTX_W'(ca));
            sc(same ? "R1 R2 sweep sc" : "R3 sweep sc", ab, CTX_W'(cb), same);
            plain("R5 sweep plain", aa, CTX_W'(ca));
            sc("R5 after plain", aa, CTX_W'(ca), 0);
          end
        end
      end
    end

    // R6: success clears other contexts on the granule
    ll(gaddr(7, 0), 3'd1);
    ll(gaddr(7, 4), 3'd2);
    sc("R6 owner sc", gaddr(7, 8), 3'd1, 1);
    sc("R6 other ctx cleared", gaddr(7, 0), 3'd2, 0);

    // R7: failed sc changes nothing
    ll(gaddr(8, 0), 3'd1);
    sc("R7 wrong ctx", gaddr(8, 0), 3'd2, 0);
    sc("R7 reservation kept", gaddr(8, 3), 3'd1, 1);

    // R8: replacement per context
    ll(gaddr(9, 0), 3'd4);
    ll(gaddr(10, 0), 3'd4);
    sc("R8 old granule", gaddr(9, 0), 3'd4, 0);
    sc("R8 new granule", gaddr(10, 0), 3'd4, 1);

    // R9: eviction of the oldest when full
    do_reset();
    for (int k = 0; k < ENTRIES; k++) ll(gaddr(20 + k, 0), CTX_W'(k));
    ll(gaddr(30, 0), 3'd6);
    sc("R9 oldest evicted", gaddr(20, 0), 3'd0, 0);
    for (int k = 1; k < ENTRIES; k++) sc("R9 survivor", gaddr(20 + k, 0), CTX_W'(k), 1);
    sc("R9 newest", gaddr(30, 0), 3'd6, 1);

    // R10: simultaneous plain store and linked load, same granule
    cycle_req("R10 store with ll", 1, gaddr(40, 2), 3'd2, 0, 1, gaddr(40, 6), 3'd3, 1, 1, 0);
    sc("R10 ll survives", gaddr(40, 0), 3'd3, 1);

    // R12: plain load takes nothing
    cycle_req("R12 plain load", 0, '0, '0, 0, 1, gaddr(41, 0), 3'd5, 0, 0, 0);
    sc("R12 no reservation", gaddr(41, 0), 3'd5, 0);

    // R11: reset empties table
    ll(gaddr(42, 0), 3'd1);
    do_reset();
    check3("R11 outputs after reset", resp_valid, resp_permit, resp_result, 0, 0, 0);
    sc("R11 table emptied", gaddr(42, 0), 3'd1, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R11 actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule